// File: doc/BRIEF.md
# Gated Cycle Counter with Debug Access

This block keeps a 64-bit count of processor clock cycles. A qualifying input decides, cycle by cycle, whether the current execution state may be counted at all. When it may, the counter either advances on every such cycle or, with the slow mode selected, advances once for every 64 qualifying cycles. A 6-bit prescaler sets that pace. A clear input zeroes the whole count. When the count steps past its all-ones value it wraps to zero and pulses an overflow flag for one cycle.

An external debug bus of 32 bits sees the counter as two word windows. One byte offset holds the low word and the next word up holds the high word. Every request receives a response one cycle later. Power and lock status inputs decide whether the request is refused with an error, served read-only, or served read-write. A write to one window replaces only that half of the counter. After reset the count value is not defined by the requirements. Software is expected to clear or write it before relying on it.

Top module: `cyc_ctr_top`

## Requirements
- R1: With the slow mode off and unchanged since the previous cycle, each cycle in which `cnt_en_i` is high and no clear or accepted write occurs adds one to `count_o`, visible after that clock edge.
- R2: With `div64_i` high, `count_o` advances once per 64 cycles in which `cnt_en_i` is high. The 6-bit prescaler returns to zero on a clear and in any cycle where `div64_i` differs from its value in the previous cycle, and no increment happens in that cycle.
- R3: In a cycle where `cnt_en_i` is low and there is no clear or accepted write, `count_o` holds its value.
- R4: `clr_i` high makes `count_o` zero after the edge and resets the prescaler. A clear takes priority over a write and over an increment in the same cycle.
- R5: Byte address 0x0F8 maps counter bits 31:0 and 0x0FC maps bits 63:32. A request is answered in the next cycle with `rsp_vld_o` high. A read returns the counter value held before the request's clock edge.
- R6: A request is granted only when `core_pwr_i` is high and `dbl_lock_i`, `os_lock_i` are low and `ext_allow_i` is high. Otherwise the response has `rsp_err_o` high and `rsp_rdata_o` zero, and a write changes nothing.
- R7: A granted request with `sw_lock_i` high is read-only. A write is ignored but responds without error.
- R8: A granted write with `sw_lock_i` low replaces only the addressed 32-bit half. The written value wins over an increment in that half, and the other half takes its incremented value.
- R9: A granted request to any other address responds without error. A read there returns zero and a write there changes nothing.
- R10: When an increment takes the count from all ones, the count becomes zero and `ovf_o` is high for exactly the following cycle. A clear or write in that cycle suppresses the pulse.
- R11: During and right after reset, `ovf_o`, `rsp_vld_o` and `rsp_err_o` are low and the prescaler is at zero. The reset value of `count_o` is not specified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_en_i | input | 1 | Counting permitted in the current state |
| div64_i | input | 1 | Slow mode: one step per 64 qualifying cycles |
| clr_i | input | 1 | Zero the counter and prescaler |
| dbg_req_i | input | 1 | Debug request strobe |
| dbg_wr_i | input | 1 | Request is a write |
| dbg_addr_i | input | 12 | Debug byte address |
| dbg_wdata_i | input | 32 | Write data |
| core_pwr_i | input | 1 | Core powered |
| dbl_lock_i | input | 1 | Double lock set |
| os_lock_i | input | 1 | OS lock set |
| ext_allow_i | input | 1 | External monitor access permitted |
| sw_lock_i | input | 1 | Software lock set (read-only) |
| rsp_vld_o | output | 1 | Response valid, one cycle after request |
| rsp_err_o | output | 1 | Request refused |
| rsp_rdata_o | output | 32 | Read data |
| count_o | output | 64 | Current count |
| ovf_o | output | 1 | One-cycle wrap pulse |

## Verification
The bench goes after a write landing in the same cycle as an increment. A design that lets the increment win, or that clobbers the other half, would show the wrong word. It steps through the slow mode across mode flips and clears, where a prescaler that is not reset would take its first step early. It drives the wrap from all ones, where a missing or stretched pulse would show up. It also walks the full lock and power matrix: a design that wrote through under the software lock or under a refused grant would corrupt the count, and returning stale data on errors or unmapped reads would break the zero-data rule.

// File: rtl/ccnt_pkg.sv
package ccnt_pkg;

  typedef enum logic [1:0] {
    ACC_DENY = 2'd0,
    ACC_RO   = 2'd1,
    ACC_RW   = 2'd2
  } acc_e;

  // Decide how a debug request is serviced from power and lock state.
  function automatic acc_e classify(input logic pwr, input logic dlock,
                                    input logic oslock, input logic ext_ok,
                                    input logic swlock);
    if (!(pwr && !dlock && !oslock && ext_ok)) return ACC_DENY;
    if (swlock) return ACC_RO;
    return ACC_RW;
  endfunction

endpackage

// File: rtl/ccnt_presc.sv
module ccnt_presc #(
  parameter int PRE_W = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic div_i,
  input  logic clr_i,
  output logic tick_o,
  output logic mode_q_o
);
  logic [PRE_W-1:0] pre_q;
  logic             div_q;
  logic             mode_chg;

  assign mode_chg = div_i ^ div_q;
  assign mode_q_o = div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      div_q <= 1'b0;
    end else begin
      div_q <= div_i;
      if (clr_i || mode_chg)   pre_q <= '0;
      else if (en_i && div_i)  pre_q <= pre_q + 1'b1;
    end
  end

  always_comb begin
    tick_o = 1'b0;
    if (en_i && !clr_i && !mode_chg)
      tick_o = div_i ? (&pre_q) : 1'b1;
  end
endmodule

// File: rtl/ccnt_core.sv
module ccnt_core #(
  parameter int CNT_W  = 64,
  parameter int DATA_W = 32,
  localparam int NWIN  = CNT_W / DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              clr_i,
  input  logic [NWIN-1:0]   wr_stb_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              ovf_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] inc_val;
  logic [CNT_W-1:0] nxt_val;
  logic             wrap;

  assign inc_val = cnt_q + {{(CNT_W-1){1'b0}}, tick_i};
  assign wrap    = tick_i && (&cnt_q);

  for (genvar gi = 0; gi < NWIN; gi++) begin : g_win
    assign nxt_val[gi*DATA_W +: DATA_W] =
      wr_stb_i[gi] ? wdata_i : inc_val[gi*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_o <= 1'b0;
    end else begin
      cnt_q <= clr_i ? '0 : nxt_val;
      ovf_o <= !clr_i && wrap && !(|wr_stb_i);
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/ccnt_dbg.sv
module ccnt_dbg
  import ccnt_pkg::*;
#(
  parameter int             CNT_W  = 64,
  parameter int             DATA_W = 32,
  parameter int             ADDR_W = 12,
  parameter logic [ADDR_W-1:0] BASE = 12'h0F8,
  localparam int            NWIN   = CNT_W / DATA_W,
  localparam int            STRIDE = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              pwr_i,
  input  logic              dlock_i,
  input  logic              oslock_i,
  input  logic              ext_i,
  input  logic              swlock_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [NWIN-1:0]   wr_stb_o,
  output logic              rsp_vld_o,
  output logic              rsp_err_o,
  output logic [DATA_W-1:0] rsp_rdata_o
);
  acc_e              acc;
  logic [NWIN-1:0]   hit;
  logic [DATA_W-1:0] rd_mux;

  assign acc = classify(pwr_i, dlock_i, oslock_i, ext_i, swlock_i);

  for (genvar gi = 0; gi < NWIN; gi++) begin : g_dec
    assign hit[gi]      = (addr_i == BASE + ADDR_W'(gi * STRIDE));
    assign wr_stb_o[gi] = req_i && wr_i && (acc == ACC_RW) && hit[gi];
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NWIN; i++)
      if (hit[i]) rd_mux = rd_mux | cnt_i[i*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_vld_o   <= 1'b0;
      rsp_err_o   <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_vld_o   <= req_i;
      rsp_err_o   <= req_i && (acc == ACC_DENY);
      rsp_rdata_o <= (req_i && !wr_i && (acc != ACC_DENY)) ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/cyc_ctr_top.sv
module cyc_ctr_top #(
  parameter int CNT_W  = 64,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12,
  parameter int PRE_W  = 6,
  parameter logic [ADDR_W-1:0] BASE = 12'h0F8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_en_i,
  input  logic              div64_i,
  input  logic              clr_i,
  input  logic              dbg_req_i,
  input  logic              dbg_wr_i,
  input  logic [ADDR_W-1:0] dbg_addr_i,
  input  logic [DATA_W-1:0] dbg_wdata_i,
  input  logic              core_pwr_i,
  input  logic              dbl_lock_i,
  input  logic              os_lock_i,
  input  logic              ext_allow_i,
  input  logic              sw_lock_i,
  output logic              rsp_vld_o,
  output logic              rsp_err_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              ovf_o
);
  localparam int NWIN = CNT_W / DATA_W;

  logic            tick;
  logic            mode_q;
  logic [NWIN-1:0] wr_stb;
  logic            wr_any;

  assign wr_any = |wr_stb;

  ccnt_presc #(.PRE_W(PRE_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .en_i(cnt_en_i), .div_i(div64_i),
    .clr_i(clr_i), .tick_o(tick), .mode_q_o(mode_q)
  );

  ccnt_dbg #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BASE(BASE)) u_dbg (
    .clk(clk), .rst_n(rst_n), .req_i(dbg_req_i), .wr_i(dbg_wr_i),
    .addr_i(dbg_addr_i), .pwr_i(core_pwr_i), .dlock_i(dbl_lock_i),
    .oslock_i(os_lock_i), .ext_i(ext_allow_i), .swlock_i(sw_lock_i),
    .cnt_i(count_o), .wr_stb_o(wr_stb), .rsp_vld_o(rsp_vld_o),
    .rsp_err_o(rsp_err_o), .rsp_rdata_o(rsp_rdata_o)
  );

  ccnt_core #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .clr_i(clr_i),
    .wr_stb_i(wr_stb), .wdata_i(dbg_wdata_i), .cnt_o(count_o), .ovf_o(ovf_o)
  );
endmodule

// File: rtl/ccnt_chk.sv
module ccnt_chk #(
  parameter int CNT_W  = 64,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cnt_en_i,
  input logic              div64_i,
  input logic              clr_i,
  input logic              dbg_req_i,
  input logic              rsp_vld_o,
  input logic              rsp_err_o,
  input logic [DATA_W-1:0] rsp_rdata_o,
  input logic [CNT_W-1:0]  count_o,
  input logic              ovf_o,
  input logic              tick,
  input logic              mode_q,
  input logic              wr_any
);
  p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en_i && !div64_i && !mode_q && !clr_i && !wr_any)
      |=> count_o == $past(count_o) + CNT_W'(1));

  p_slow_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (div64_i && !tick && !clr_i && !wr_any) |=> count_o == $past(count_o));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en_i && !clr_i && !wr_any) |=> count_o == $past(count_o));

  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (count_o == '0 && !ovf_o));

  p_resp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_req_i |=> rsp_vld_o);

  p_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !dbg_req_i |=> (!rsp_vld_o && !rsp_err_o));

  p_err_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err_o |-> (rsp_vld_o && rsp_rdata_o == '0));

  p_ovf_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |-> count_o == '0);

  p_ovf_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> !ovf_o);

  always @(posedge clk)
    if (!rst_n) begin
      a_rst_r11: assert (!ovf_o && !rsp_vld_o && !rsp_err_o);
    end
endmodule

bind cyc_ctr_top ccnt_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_en_i(cnt_en_i), .div64_i(div64_i),
  .clr_i(clr_i), .dbg_req_i(dbg_req_i), .rsp_vld_o(rsp_vld_o),
  .rsp_err_o(rsp_err_o), .rsp_rdata_o(rsp_rdata_o), .count_o(count_o),
  .ovf_o(ovf_o), .tick(tick), .mode_q(mode_q), .wr_any(wr_any)
);

// File: tb/tb_cyc_ctr_top.sv
`timescale 1ns/1ps
module tb_cyc_ctr_top;
  localparam logic [11:0] A_LO = 12'h0F8;
  localparam logic [11:0] A_HI = 12'h0FC;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en_i = 0, div64_i = 0, clr_i = 0;
  logic        dbg_req_i = 0, dbg_wr_i = 0;
  logic [11:0] dbg_addr_i = '0;
  logic [31:0] dbg_wdata_i = '0;
  logic        core_pwr_i = 1, dbl_lock_i = 0, os_lock_i = 0, ext_allow_i = 1, sw_lock_i = 0;
  logic        rsp_vld_o, rsp_err_o, ovf_o;
  logic [31:0] rsp_rdata_o;
  logic [63:0] count_o;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cyc_ctr_top dut (.*);

  // ---- reference model, updated from the requirements at each edge ----
  logic [63:0] m_cnt;
  logic [5:0]  m_pre;
  logic        m_div_q, m_ovf, m_vld, m_err, m_known;
  logic [31:0] m_rdata;

  function automatic bit granted();
    return core_pwr_i && !dbl_lock_i && !os_lock_i && ext_allow_i;
  endfunction

  function automatic logic [31:0] read_word(logic [63:0] c, logic [11:0] a);
    if (a == A_LO) return c[31:0];
    if (a == A_HI) return c[63:32];
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pre = 0; m_div_q = 0; m_ovf = 0; m_vld = 0; m_err = 0; m_rdata = 0;
    end else begin
      bit g, tk, wl, wh, wrap;
      logic [63:0] nx;
      g = granted();
      m_vld = dbg_req_i;
      m_err = dbg_req_i && !g;
      m_rdata = (dbg_req_i && g && !dbg_wr_i) ? read_word(m_cnt, dbg_addr_i) : 32'h0;
      tk = 0;
      if (clr_i || (div64_i != m_div_q)) m_pre = 0;
      else if (cnt_en_i) begin
        if (div64_i) begin tk = (m_pre == 6'd63); m_pre = m_pre + 1; end
        else tk = 1;
      end
      m_div_q = div64_i;
      wl = dbg_req_i && dbg_wr_i && g && !sw_lock_i && dbg_addr_i == A_LO;
      wh = dbg_req_i && dbg_wr_i && g && !sw_lock_i && dbg_addr_i == A_HI;
      wrap = tk && (m_cnt == '1);
      nx = m_cnt + 64'(tk);
      if (wl) nx[31:0] = dbg_wdata_i;
      if (wh) nx[63:32] = dbg_wdata_i;
      if (clr_i) begin nx = 0; m_known = 1; end
      m_ovf = !clr_i && wrap && !wl && !wh;
      m_cnt = nx;
    end
  end

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---- cycle monitor against the model ----
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R5 rsp_vld", 64'(rsp_vld_o), 64'(m_vld));
      check("R6 rsp_err", 64'(rsp_err_o), 64'(m_err));
      if (m_known) begin
        check("R1/R2/R3/R4/R8 count", count_o, m_cnt);
        check("R10 ovf", 64'(ovf_o), 64'(m_ovf));
        check("R5/R9 rdata", 64'(rsp_rdata_o), 64'(m_rdata));
      end
    end
  end

  task automatic idle();
    dbg_req_i = 0; dbg_wr_i = 0; clr_i = 0;
  endtask

  task automatic dbg(bit wr, logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    idle(); cnt_en_i = 0;
    dbg_req_i = 1; dbg_wr_i = wr; dbg_addr_i = a; dbg_wdata_i = d;
    @(negedge clk);
    idle();
  endtask

  initial begin
    m_cnt = 0; m_known = 0;
    repeat (3) @(negedge clk);
    check("R11 ovf in reset", 64'(ovf_o), 0);
    check("R11 rsp_vld in reset", 64'(rsp_vld_o), 0);
    check("R11 rsp_err in reset", 64'(rsp_err_o), 0);
    rst_n = 1;

    // R4: clear, also beating a write in the same cycle
    @(negedge clk); clr_i = 1; dbg_req_i = 1; dbg_wr_i = 1; dbg_addr_i = A_LO; dbg_wdata_i = 32'h55;
    @(negedge clk); idle();
    check("R4 clear wins", count_o, 0);

    // R1: ten counted cycles
    cnt_en_i = 1;
    repeat (10) @(negedge clk);
    cnt_en_i = 0;
    check("R1 ten steps", count_o, 10);
    // R3: filter low holds
    repeat (5) @(negedge clk);
    check("R3 hold", count_o, 10);

    // R2: slow mode, mode change together with clear
    div64_i = 1; clr_i = 1;
    @(negedge clk); clr_i = 0; cnt_en_i = 1;
    repeat (63) @(negedge clk);
    check("R2 63 slow cycles", count_o, 0);
    @(negedge clk);
    check("R2 64th slow cycle", count_o, 1);
    cnt_en_i = 0; div64_i = 0;
    @(negedge clk);

    // R10: wrap from all ones
    dbg(1, A_LO, 32'hFFFF_FFFF);
    dbg(1, A_HI, 32'hFFFF_FFFF);
    check("R8 both halves written", count_o, 64'hFFFF_FFFF_FFFF_FFFF);
    cnt_en_i = 1;
    @(negedge clk); cnt_en_i = 0;
    check("R10 wrap value", count_o, 0);
    check("R10 ovf high", 64'(ovf_o), 1);
    @(negedge clk);
    check("R10 ovf one cycle", 64'(ovf_o), 0);

    // R8: write high half while incrementing
    @(negedge clk); cnt_en_i = 1; dbg_req_i = 1; dbg_wr_i = 1; dbg_addr_i = A_HI; dbg_wdata_i = 32'h5;
    @(negedge clk); idle(); cnt_en_i = 0;
    check("R8 half write + step", count_o, 64'h0000_0005_0000_0001);

    // R7: software lock makes writes ignored without error
    sw_lock_i = 1;
    dbg(1, A_LO, 32'h1234);
    check("R7 no error", 64'(rsp_err_o), 0);
    check("R7 value kept", count_o, 64'h0000_0005_0000_0001);
    dbg(0, A_HI, 0);
    check("R5 read high under lock", 64'(rsp_rdata_o), 5);
    sw_lock_i = 0;

    // R6: refused when powered down
    core_pwr_i = 0;
    dbg(1, A_LO, 32'h9);
    check("R6 error", 64'(rsp_err_o), 1);
    check("R6 zero data", 64'(rsp_rdata_o), 0);
    check("R6 no write", count_o, 64'h0000_0005_0000_0001);
    core_pwr_i = 1;

    // R9: unmapped
    dbg(0, 12'h100, 0);
    check("R9 unmapped read", 64'(rsp_rdata_o), 0);
    check("R9 no error", 64'(rsp_err_o), 0);
    dbg(1, 12'h0F4, 32'hABCD);
    check("R9 unmapped write", count_o, 64'h0000_0005_0000_0001);
    dbg(0, A_LO, 0);
    check("R5 read low", 64'(rsp_rdata_o), 1);

    // Random phase, checked by the cycle monitor
    void'($urandom(32'd2024));
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      cnt_en_i    = ($urandom % 10) != 0;
      clr_i       = ($urandom % 150) == 0;
      if (($urandom % 400) == 0) div64_i = ~div64_i;
      dbg_req_i   = ($urandom % 3) == 0;
      dbg_wr_i    = $urandom % 2;
      dbg_addr_i  = ($urandom % 5 == 0) ? 12'($urandom) : (($urandom % 2) ? A_HI : A_LO);
      dbg_wdata_i = ($urandom % 4 == 0) ? 32'hFFFF_FFFF : $urandom;
      core_pwr_i  = ($urandom % 10) != 0;
      dbl_lock_i  = ($urandom % 10) == 0;
      os_lock_i   = ($urandom % 10) == 0;
      ext_allow_i = ($urandom % 10) != 0;
      sw_lock_i   = ($urandom % 4) == 0;
    end
    @(negedge clk); idle();
    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule